// File: doc/BRIEF.md
# Conservative Coarse Depth Rejection

This block keeps a small grid of coarse depth values, one per screen tile, and uses it to throw away fragments that cannot be visible before they reach shading. Each draw loads its state: compare function, depth-bounds enable, early-test mode, and shader and pipeline flags such as kill/discard, depth write, alpha test, stencil test, blend and side effects. From that state, and from the history of compare directions since the last clear, the block decides whether coarse testing and coarse writing are allowed for that draw.

Fragments arrive as a tile X/Y index plus a 16-bit unsigned depth. Each one gets a pass or reject verdict one cycle later. A passing fragment can refresh its tile's entry only when its survival through the rest of the pipeline is certain. Because of this rule, the stored values are always a conservative bound. A change of compare direction between draws turns coarse testing and writing off until the grid is cleared. A clear pulse empties every tile and re-arms direction tracking from the draw that is loaded at that moment.

Top module: `zcoarse_reject`

## Requirements
- R1: `zTestEnable` is high when the loaded compare function is not NEVER (0) or ALWAYS (7), or when depth-bounds testing is enabled. Compare codes: NEVER 0, LESS 1, EQUAL 2, LEQUAL 3, GREATER 4, NOTEQUAL 5, GEQUAL 6, ALWAYS 7.
- R2: `earlyZOn` is high only when the early mode is 0 (early depth test plus coarse test). Mode 1 disables both early tests. Mode 2 is coarse test only, with a late full depth test. Mode 3 behaves like mode 1.
- R3: `coarseTestOn` is high when all of these hold: the mode is 0 or 2, the function is directional (LESS or LEQUAL for the less type, GREATER or GEQUAL for the greater type), the shader neither writes depth nor has side effects, and no reversal is latched. A kill/discard shader does not block the test.
- R4: `coarseWriteOn` is high when `coarseTestOn` is high and none of these is set: kill/discard, depth write, alpha test, stencil test, blend.
- R5: A draw whose compare direction is opposite to the tracked direction latches a reversal. The reversal forces coarse test and write off for that draw and every later draw until a clear. A clear sets the tracked direction from the loaded draw's function. A non-directional function leaves the tracker unset.
- R6: A fragment presented with `fragValid` produces `outValid` on the next cycle, with its verdict on `outPass`. No fragment means no result.
- R7: A fragment whose tile has not been written since reset or the last clear always passes.
- R8: When the coarse test is on and the tile holds a value S, the verdict for fragment depth Z is as follows. LESS rejects Z >= S. LEQUAL rejects Z > S. GREATER rejects Z <= S. GEQUAL rejects Z < S. When the coarse test is off, every fragment passes.
- R9: A passing fragment updates its tile only when coarse write is on. For less-type functions the tile keeps the minimum depth; for greater-type functions it keeps the maximum. Rejected fragments and fragments drawn while write is off leave the tile unchanged.
- R10: The tile index is {tileY, tileX}. A fragment reads and updates only its own tile.
- R11: A clear returns every tile to the unwritten state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| drawLoad | input | 1 | Latch the per-draw state on this cycle |
| drawFunc | input | 3 | Depth compare function code |
| drawBoundsEn | input | 1 | Depth-bounds test enabled |
| drawKill | input | 1 | Shader may kill/discard |
| drawWritesZ | input | 1 | Shader writes depth |
| drawAlphaTest | input | 1 | Alpha test enabled |
| drawStencilTest | input | 1 | Stencil test enabled |
| drawBlend | input | 1 | Blending enabled |
| drawSideFx | input | 1 | Shader has memory side effects |
| drawMode | input | 2 | Early-test mode |
| clearReq | input | 1 | Clear all tiles and re-arm direction tracking |
| fragValid | input | 1 | Fragment present |
| fragTileX | input | 3 | Tile column |
| fragTileY | input | 3 | Tile row |
| fragZ | input | 16 | Fragment depth, unsigned |
| outValid | output | 1 | Verdict valid |
| outPass | output | 1 | 1 = fragment survives, 0 = rejected |
| zTestEnable | output | 1 | Depth test enable flag for the loaded draw |
| earlyZOn | output | 1 | Early full depth test allowed |
| coarseTestOn | output | 1 | Coarse test allowed |
| coarseWriteOn | output | 1 | Coarse write allowed |

## Verification
The bench checks the equality edge of each compare function: a depth equal to the stored value must be rejected by LESS and GREATER and kept by LEQUAL and GEQUAL. An off-by-one comparator would drop visible fragments, or keep ones the buffer already rules out. A second set of scenarios runs a kill shader, then a blend draw, and then probes the same tile with a depth beyond the earlier one. A design that wrote anyway would reject that probe, which shows the stored bound is no longer conservative. Reversal sequences check that a reversal stays latched across a later draw in the original direction and is undone only by a clear. A sweep of all 64 tiles catches index swaps between X and Y.

// File: rtl/zc_pkg.sv
package zc_pkg;

  typedef enum logic [2:0] {
    ZF_NEVER    = 3'd0,
    ZF_LESS     = 3'd1,
    ZF_EQUAL    = 3'd2,
    ZF_LEQUAL   = 3'd3,
    ZF_GREATER  = 3'd4,
    ZF_NOTEQUAL = 3'd5,
    ZF_GEQUAL   = 3'd6,
    ZF_ALWAYS   = 3'd7
  } zFunc_e;

  typedef enum logic [1:0] {
    EM_BOTH       = 2'd0,
    EM_NONE       = 2'd1,
    EM_COARSE_ONLY = 2'd2,
    EM_RSVD       = 2'd3
  } earlyMode_e;

  typedef enum logic [1:0] {
    TR_UNSET   = 2'd0,
    TR_LESS    = 2'd1,
    TR_GREATER = 2'd2,
    TR_LOCKED  = 2'd3
  } dirTrack_e;

  typedef struct packed {
    logic [2:0] func;
    logic       boundsEn;
    logic       kill;
    logic       writesZ;
    logic       alphaTest;
    logic       stencilTest;
    logic       blend;
    logic       sideFx;
    logic [1:0] mode;
  } drawState_t;

  // strobes from the draw control to the tile datapath
  typedef struct packed {
    logic testOn;
    logic writeOn;
    logic dirGreater;
    logic inclusive;
    logic clearNow;
  } zcStrobe_t;

  function automatic dirTrack_e dirOf(logic [2:0] f);
    case (f)
      ZF_LESS, ZF_LEQUAL:      dirOf = TR_LESS;
      ZF_GREATER, ZF_GEQUAL:   dirOf = TR_GREATER;
      default:                 dirOf = TR_UNSET;
    endcase
  endfunction

endpackage

// File: rtl/zc_draw_ctrl.sv
module zc_draw_ctrl
  import zc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       drawLoad,
  input  drawState_t drawIn,
  input  logic       clearReq,
  output zcStrobe_t  strobe,
  output logic       zTestEnable,
  output logic       earlyZOn,
  output logic       coarseTestOn,
  output logic       coarseWriteOn
);

  drawState_t cur;
  dirTrack_e  track, trackNext;
  dirTrack_e  curDir, loadDir, clearDir;
  logic       modeAllows, testOk, writeOk, writeBlockers;

  // per-draw state register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '{func: ZF_NEVER, mode: EM_NONE, default: 1'b0};
    end else if (drawLoad) begin
      cur <= drawIn;
    end
  end

  // direction tracker
  always_comb begin
    loadDir   = dirOf(drawIn.func);
    clearDir  = drawLoad ? loadDir : dirOf(cur.func);
    trackNext = track;
    if (clearReq) begin
      trackNext = clearDir;
    end else if (drawLoad && loadDir != TR_UNSET && track != TR_LOCKED) begin
      if (track == TR_UNSET)      trackNext = loadDir;
      else if (track != loadDir)  trackNext = TR_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) track <= TR_UNSET;
    else       track <= trackNext;
  end

  // enables for the loaded draw
  always_comb begin
    curDir        = dirOf(cur.func);
    modeAllows    = (cur.mode == EM_BOTH) || (cur.mode == EM_COARSE_ONLY);
    testOk        = modeAllows && (curDir != TR_UNSET) && (track != TR_LOCKED)
                    && !cur.writesZ && !cur.sideFx;
    writeBlockers = cur.kill | cur.writesZ | cur.alphaTest | cur.stencilTest | cur.blend;
    writeOk       = testOk && !writeBlockers;
  end

  assign zTestEnable   = ((cur.func != ZF_NEVER) && (cur.func != ZF_ALWAYS)) || cur.boundsEn;
  assign earlyZOn      = (cur.mode == EM_BOTH);
  assign coarseTestOn  = testOk;
  assign coarseWriteOn = writeOk;

  assign strobe.testOn     = testOk;
  assign strobe.writeOn    = writeOk;
  assign strobe.dirGreater = (curDir == TR_GREATER);
  assign strobe.inclusive  = (cur.func == ZF_LEQUAL) || (cur.func == ZF_GEQUAL);
  assign strobe.clearNow   = clearReq;

  // a latched reversal survives every later draw until a clear
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (track == TR_LOCKED && !clearReq) |=> (track == TR_LOCKED));

  // an opposite-direction draw against a tracked direction latches the reversal
  p_reversal_locks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (drawLoad && !clearReq && track == TR_LESS && dirOf(drawIn.func) == TR_GREATER)
      |=> (track == TR_LOCKED && !coarseTestOn && !coarseWriteOn));

  // a clear always re-arms
  p_clear_rearms_r5: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (track != TR_LOCKED));

  // disabled early mode never allows coarse activity
  p_mode_gates_test_r3: assert property (@(posedge clk) disable iff (!rstN)
    (drawLoad && drawIn.mode == EM_NONE) |=> (!coarseTestOn && !earlyZOn));

endmodule

// File: rtl/zc_tile_array.sv
module zc_tile_array
  import zc_pkg::*;
#(
  parameter int Z_W      = 16,
  parameter int TILE_X_W = 3,
  parameter int TILE_Y_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  zcStrobe_t           strobe,
  input  logic                fragValid,
  input  logic [TILE_X_W-1:0] fragTileX,
  input  logic [TILE_Y_W-1:0] fragTileY,
  input  logic [Z_W-1:0]      fragZ,
  output logic                outValid,
  output logic                outPass
);

  localparam int IDX_W = TILE_X_W + TILE_Y_W;
  localparam int TILES = 1 << IDX_W;

  logic [Z_W-1:0]   storedZ [TILES];
  logic [TILES-1:0] written;

  logic [IDX_W-1:0] idx;
  logic [Z_W-1:0]   curZ, newZ, farZ;
  logic             hit, lessFail, greatFail, cmpFail, rejectNow, doWrite;

  always_comb begin
    idx       = {fragTileY, fragTileX};
    hit       = written[idx];
    curZ      = storedZ[idx];
    lessFail  = strobe.inclusive ? (fragZ >  curZ) : (fragZ >= curZ);
    greatFail = strobe.inclusive ? (fragZ <  curZ) : (fragZ <= curZ);
    cmpFail   = strobe.dirGreater ? greatFail : lessFail;
    rejectNow = strobe.testOn && hit && cmpFail;
    doWrite   = fragValid && strobe.writeOn && !rejectNow && !strobe.clearNow;
    farZ      = strobe.dirGreater ? '0 : '1;
    if (!hit)                   newZ = fragZ;
    else if (strobe.dirGreater) newZ = (fragZ > curZ) ? fragZ : curZ;
    else                        newZ = (fragZ < curZ) ? fragZ : curZ;
  end

  for (genvar t = 0; t < TILES; t++) begin : g_tile
    always_ff @(posedge clk) begin
      if (!rstN) begin
        storedZ[t] <= '1;
        written[t] <= 1'b0;
      end else if (strobe.clearNow) begin
        storedZ[t] <= farZ;
        written[t] <= 1'b0;
      end else if (doWrite && idx == IDX_W'(t)) begin
        storedZ[t] <= newZ;
        written[t] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPass  <= 1'b0;
    end else begin
      outValid <= fragValid;
      outPass  <= !rejectNow;
    end
  end

  p_result_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    fragValid |=> outValid);

  p_no_spurious_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fragValid |=> !outValid);

  p_reject_needs_test_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outPass) |-> $past(strobe.testOn));

  p_unwritten_passes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && !written[idx]) |=> outPass);

  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearNow |=> (written == '0));

  p_write_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.writeOn && !strobe.clearNow) |=> $stable(written));

endmodule

// File: rtl/zcoarse_reject.sv
module zcoarse_reject
  import zc_pkg::*;
#(
  parameter int Z_W      = 16,
  parameter int TILE_X_W = 3,
  parameter int TILE_Y_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                drawLoad,
  input  logic [2:0]          drawFunc,
  input  logic                drawBoundsEn,
  input  logic                drawKill,
  input  logic                drawWritesZ,
  input  logic                drawAlphaTest,
  input  logic                drawStencilTest,
  input  logic                drawBlend,
  input  logic                drawSideFx,
  input  logic [1:0]          drawMode,
  input  logic                clearReq,
  input  logic                fragValid,
  input  logic [TILE_X_W-1:0] fragTileX,
  input  logic [TILE_Y_W-1:0] fragTileY,
  input  logic [Z_W-1:0]      fragZ,
  output logic                outValid,
  output logic                outPass,
  output logic                zTestEnable,
  output logic                earlyZOn,
  output logic                coarseTestOn,
  output logic                coarseWriteOn
);

  drawState_t drawIn;
  zcStrobe_t  strobe;

  assign drawIn = '{func: drawFunc, boundsEn: drawBoundsEn, kill: drawKill,
                    writesZ: drawWritesZ, alphaTest: drawAlphaTest,
                    stencilTest: drawStencilTest, blend: drawBlend,
                    sideFx: drawSideFx, mode: drawMode};

  zc_draw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .drawLoad     (drawLoad),
    .drawIn       (drawIn),
    .clearReq     (clearReq),
    .strobe       (strobe),
    .zTestEnable  (zTestEnable),
    .earlyZOn     (earlyZOn),
    .coarseTestOn (coarseTestOn),
    .coarseWriteOn(coarseWriteOn)
  );

  zc_tile_array #(
    .Z_W     (Z_W),
    .TILE_X_W(TILE_X_W),
    .TILE_Y_W(TILE_Y_W)
  ) u_tiles (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fragValid(fragValid),
    .fragTileX(fragTileX),
    .fragTileY(fragTileY),
    .fragZ    (fragZ),
    .outValid (outValid),
    .outPass  (outPass)
  );

endmodule

// File: tb/tb_zcoarse_reject.sv
module tb_zcoarse_reject;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        drawLoad = 1'b0;
  logic [2:0]  drawFunc = 3'd0;
  logic        drawBoundsEn = 1'b0, drawKill = 1'b0, drawWritesZ = 1'b0;
  logic        drawAlphaTest = 1'b0, drawStencilTest = 1'b0, drawBlend = 1'b0;
  logic        drawSideFx = 1'b0;
  logic [1:0]  drawMode = 2'd1;
  logic        clearReq = 1'b0;
  logic        fragValid = 1'b0;
  logic [2:0]  fragTileX = 3'd0, fragTileY = 3'd0;
  logic [15:0] fragZ = 16'd0;
  logic        outValid, outPass, zTestEnable, earlyZOn, coarseTestOn, coarseWriteOn;

  always #5 clk = ~clk;

  zcoarse_reject dut (.*);

  int    total = 0, bad = 0;
  bit    finished = 0;
  bit    expQ[$];
  string tagQ[$];

  // bench-side model state
  bit mValid[64];
  int mZ[64];
  int mTrack = 0; // 0 unset, 1 less, 2 greater, 3 locked
  int mFunc = 0, mMode = 1;
  bit mBounds, mKill, mWz, mAlpha, mSten, mBlend, mFx;

  function automatic int dirOfF(int f);
    if (f == 1 || f == 3) return 1;
    if (f == 4 || f == 6) return 2;
    return 0;
  endfunction

  function automatic bit expTest();
    return (mMode == 0 || mMode == 2) && dirOfF(mFunc) != 0 && mTrack != 3 && !mWz && !mFx;
  endfunction

  function automatic bit expWrite();
    return expTest() && !mKill && !mWz && !mAlpha && !mSten && !mBlend;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setDraw(int f, bit bnd, bit kl, bit wz, bit al, bit st, bit bl, bit fx, int md);
    int d;
    @(posedge clk); #1;
    fragValid = 0;
    drawFunc = 3'(f); drawBoundsEn = bnd; drawKill = kl; drawWritesZ = wz;
    drawAlphaTest = al; drawStencilTest = st; drawBlend = bl; drawSideFx = fx;
    drawMode = 2'(md); drawLoad = 1;
    d = dirOfF(f);
    if (d != 0 && mTrack != 3) begin
      if (mTrack == 0) mTrack = d;
      else if (mTrack != d) mTrack = 3;
    end
    mFunc = f; mBounds = bnd; mKill = kl; mWz = wz; mAlpha = al; mSten = st;
    mBlend = bl; mFx = fx; mMode = md;
    @(posedge clk); #1;
    drawLoad = 0;
    @(negedge clk);
    chk("R1 zTestEnable", zTestEnable, int'(((f != 0) && (f != 7)) || bnd));
    chk("R2 earlyZOn", earlyZOn, int'(md == 0));
    chk("R3/R5 coarseTestOn", coarseTestOn, int'(expTest()));
    chk("R4 coarseWriteOn", coarseWriteOn, int'(expWrite()));
  endtask

  task automatic doClear();
    @(posedge clk); #1;
    fragValid = 0;
    clearReq = 1;
    mTrack = dirOfF(mFunc);
    for (int i = 0; i < 64; i++) mValid[i] = 0;
    @(posedge clk); #1;
    clearReq = 0;
    @(negedge clk);
    chk("R5 test after clear", coarseTestOn, int'(expTest()));
  endtask

  // driver: predicts the verdict, updates the model, pushes to the scoreboard
  task automatic sendFrag(int x, int y, int z, string tag);
    int i, s, d;
    bit incl, fail, pass;
    @(posedge clk); #1;
    i = y * 8 + x;
    s = mZ[i];
    d = dirOfF(mFunc);
    incl = (mFunc == 3 || mFunc == 6);
    if (d == 2) fail = incl ? (z < s) : (z <= s);
    else        fail = incl ? (z > s) : (z >= s);
    pass = !(expTest() && mValid[i] && fail);
    if (pass && expWrite()) begin
      mValid[i] = 1;
      mZ[i] = z;
    end
    expQ.push_back(pass);
    tagQ.push_back(tag);
    fragValid = 1;
    fragTileX = 3'(x);
    fragTileY = 3'(y);
    fragZ = 16'(z);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      fragValid = 0;
    end
  endtask

  // monitor: pops the scoreboard on every verdict
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        chk("R6 unexpected verdict", 1, 0);
      end else begin
        bit e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, int'(outPass), int'(e));
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R6 reset outValid", outValid, 0);
    chk("R1 reset zTestEnable", zTestEnable, 0);
    chk("R3 reset coarseTestOn", coarseTestOn, 0);
    chk("R2 reset earlyZOn", earlyZOn, 0);
    @(posedge clk); #1;
    rstN = 1;
    idle(2);

    // clean LESS draw, both early tests
    setDraw(1, 0, 0, 0, 0, 0, 0, 0, 0);
    sendFrag(1, 2, 1000, "R7 first write passes");
    sendFrag(1, 2, 1200, "R8 LESS behind rejects");
    sendFrag(1, 2, 1000, "R8 LESS equal rejects");
    sendFrag(1, 2, 500, "R9 LESS nearer passes");
    sendFrag(3, 0, 60000, "R10 other tile unwritten");
    sendFrag(2, 1, 700, "R10 swapped index unwritten");
    sendFrag(1, 2, 600, "R9 min kept at 500");
    idle(2);

    // coarse-only mode with kill shader: test on, write off
    setDraw(3, 0, 1, 0, 0, 0, 0, 0, 2);
    sendFrag(1, 2, 500, "R8 LEQUAL equal passes");
    sendFrag(1, 2, 501, "R8 LEQUAL behind rejects");
    sendFrag(1, 2, 100, "R9 kill pass no write");
    sendFrag(1, 2, 200, "R9 value still 500");
    idle(2);

    // write blockers and test blockers
    setDraw(1, 0, 0, 0, 0, 0, 1, 0, 0);
    sendFrag(1, 2, 50, "R4 blend no write");
    sendFrag(1, 2, 60, "R4 blend value unchanged");
    idle(1);
    setDraw(1, 0, 0, 0, 1, 0, 0, 0, 0);
    setDraw(1, 0, 0, 0, 0, 1, 0, 0, 0);
    setDraw(1, 0, 0, 1, 0, 0, 0, 0, 0);
    sendFrag(1, 2, 65000, "R8 test off passes");
    idle(1);
    setDraw(1, 0, 0, 0, 0, 0, 0, 1, 2);
    setDraw(1, 0, 0, 0, 0, 0, 0, 0, 1);
    sendFrag(1, 2, 65000, "R2 mode off passes");
    idle(1);
    setDraw(1, 0, 0, 0, 0, 0, 0, 0, 3);
    setDraw(7, 0, 0, 0, 0, 0, 0, 0, 0);
    setDraw(7, 1, 0, 0, 0, 0, 0, 0, 0);
    setDraw(0, 0, 0, 0, 0, 0, 0, 0, 0);
    setDraw(2, 0, 0, 0, 0, 0, 0, 0, 0);
    setDraw(5, 1, 0, 0, 0, 0, 0, 0, 2);

    // reversal
    setDraw(4, 0, 0, 0, 0, 0, 0, 0, 0);
    sendFrag(1, 2, 0, "R5 reversed test off");
    idle(1);
    setDraw(1, 0, 0, 0, 0, 0, 0, 0, 0);
    sendFrag(1, 2, 65535, "R5 still locked");
    idle(1);
    doClear();
    sendFrag(1, 2, 65535, "R11 cleared tile passes");
    sendFrag(1, 2, 65535, "R8 LESS equal after clear");
    idle(1);
    setDraw(4, 0, 0, 0, 0, 0, 0, 0, 0);
    doClear();
    sendFrag(1, 2, 300, "R7 greater first write");
    sendFrag(1, 2, 300, "R8 GREATER equal rejects");
    sendFrag(1, 2, 299, "R8 GREATER behind rejects");
    sendFrag(1, 2, 400, "R9 max grows");
    idle(1);
    setDraw(6, 0, 0, 0, 0, 0, 0, 0, 2);
    sendFrag(1, 2, 400, "R8 GEQUAL equal passes");
    sendFrag(1, 2, 399, "R8 GEQUAL behind rejects");
    idle(1);

    // sweep every tile under a clean LESS draw
    setDraw(1, 0, 0, 0, 0, 0, 0, 0, 0);
    doClear();
    for (int i = 0; i < 64; i++) sendFrag(i % 8, i / 8, 1000 + i * 37, "R10 sweep write");
    for (int i = 0; i < 64; i++) sendFrag(i % 8, i / 8, 1000 + i * 37 + ((i % 3) - 1) * 5, "R10 sweep probe");
    idle(1);
    doClear();
    for (int i = 0; i < 64; i += 9) sendFrag(i % 8, i / 8, 65000, "R11 sweep after clear");
    idle(3);

    chk("R6 scoreboard drained", expQ.size(), 0);
    finish();
  end

endmodule